// File: doc/BRIEF.md
# Dual-mode output shift register

This block holds a received data word for a host processor. It has two modes, chosen by a mode input. In load mode, a strobe from the word checker writes a parallel word into the register, and the serial output is disabled. In read mode, the host drives a slow serial clock. Each rising edge of that clock moves the word one stage toward the output and takes the serial input into the first stage. The output bit is held in a separate last-stage latch, which changes only on the falling edge of the serial clock.

The serial clock comes from outside. It is brought into the system clock domain through a chain of synchronising flops. Its edges are then turned into one-cycle enables. The host reads the word most significant bit first: one bit before the first clock, then one bit after each falling edge.

Two instances can be chained to form one longer register. The output of one feeds the serial input of the other, and both share the serial clock and the mode input. The host then reads both words in a single pass.

Top module: `dual_mode_shift_reg`

## Requirements
- R1: After synchronous reset, every stage and the output latch hold 0, so the data output reads 0.
- R2: In load mode (mode input = 1), a one-cycle load strobe stores the parallel word. Bit WIDTH-1 of that word is the first bit the host reads back.
- R3: The output enable is 0 in load mode and 1 in read mode (mode input = 0).
- R4: In read mode, each rising serial-clock edge shifts the register one stage toward bit WIDTH-1, and the serial input enters bit 0.
- R5: In read mode, the output latch takes the value of bit WIDTH-1 only on a falling serial-clock edge.
- R6: In load mode, the output latch follows bit WIDTH-1. The first bit is therefore on the output as soon as read mode starts, before any clock edge.
- R7: A load strobe that arrives in read mode has no effect on the stored word.
- R8: Serial-clock edges in load mode neither shift the register nor take in the serial input.
- R9: With two instances chained (upstream output to downstream serial input), a read of 2*WIDTH bits from the downstream output returns the downstream word, then the upstream word.
- R10: While the serial clock is high after a rising edge, the output keeps the bit it showed before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode_i | input | 1 | 1 = load mode, 0 = read mode |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| sdi_i | input | 1 | Serial input used for chaining |
| load_stb_i | input | 1 | One-cycle parallel load strobe |
| load_data_i | input | WIDTH | Parallel word to store |
| dout_o | output | 1 | Serial data output (the output latch) |
| dout_oe_o | output | 1 | Output enable for dout_o |

## Verification
- **Serial-clock edges:** an edge on the serial clock reaches the register after SYNC_STAGES synchronising flops plus one edge-detect flop. With the default of two stages, the shift or the latch update lands three system clocks after the pin changes. The bench holds each serial-clock level for six system clocks and samples just before it changes the level again, so every result has landed with margin.
- **Parallel load:** a load reaches the output latch two clocks after the strobe. The bench waits three clocks before the next step.
- **Output enable:** the enable follows the mode input in the same cycle.
- **Timing of samples:** all inputs are driven and all outputs are sampled on the falling system-clock edge.

// File: rtl/dmsr_pkg.sv
package dmsr_pkg;

    // Mode encoding, as seen on the mode input pin
    typedef enum logic {
        MODE_READ = 1'b0,
        MODE_LOAD = 1'b1
    } xfer_mode_e;

    // One-cycle events derived from the synchronised serial clock
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    localparam int DEF_WIDTH       = 8;
    localparam int DEF_SYNC_STAGES = 2;

    function automatic xfer_mode_e decode_mode(input logic pin);
        return pin ? MODE_LOAD : MODE_READ;
    endfunction

endpackage

// File: rtl/dmsr_sclk_sync.sv
module dmsr_sclk_sync
    import dmsr_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_i,
    output sclk_evt_t evt_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= sclk_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[TOP-1:0], sclk_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[TOP];
    end

    always_comb begin
        evt_o.rise = sync_q[TOP] & ~prev_q;
        evt_o.fall = ~sync_q[TOP] & prev_q;
    end
endmodule

// File: rtl/dmsr_shift_core.sv
module dmsr_shift_core
    import dmsr_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_e       mode_i,
    input  sclk_evt_t        evt_i,
    input  logic             sdi_i,
    input  logic             load_stb_i,
    input  logic [WIDTH-1:0] load_data_i,
    output logic [WIDTH-1:0] stages_o
);
    localparam int LAST = WIDTH - 1;

    logic [LAST:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (mode_i == MODE_LOAD) begin
            if (load_stb_i) stage_q <= load_data_i;
        end else if (evt_i.rise) begin
            stage_q <= {stage_q[LAST-1:0], sdi_i};
        end
    end

    assign stages_o = stage_q;
endmodule

// File: rtl/dmsr_out_stage.sv
module dmsr_out_stage
    import dmsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  xfer_mode_e mode_i,
    input  sclk_evt_t  evt_i,
    input  logic       last_bit_i,
    output logic       dout_o,
    output logic       oe_o
);
    logic latch_q;

    // Track the last stage while loading; in read mode, update on falling edges only
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
        end else if (mode_i == MODE_LOAD || evt_i.fall) begin
            latch_q <= last_bit_i;
        end
    end

    assign dout_o = latch_q;
    assign oe_o   = (mode_i == MODE_READ);
endmodule

// File: rtl/dual_mode_shift_reg.sv
module dual_mode_shift_reg
    import dmsr_pkg::*;
#(
    parameter int WIDTH       = DEF_WIDTH,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             par_mode_i,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             load_stb_i,
    input  logic [WIDTH-1:0] load_data_i,
    output logic             dout_o,
    output logic             dout_oe_o
);
    xfer_mode_e       mode;
    sclk_evt_t        sclk_evt;
    logic [WIDTH-1:0] stage_q;

    assign mode = decode_mode(par_mode_i);

    dmsr_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .evt_o  (sclk_evt)
    );

    dmsr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .evt_i       (sclk_evt),
        .sdi_i       (sdi_i),
        .load_stb_i  (load_stb_i),
        .load_data_i (load_data_i),
        .stages_o    (stage_q)
    );

    dmsr_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .evt_i      (sclk_evt),
        .last_bit_i (stage_q[WIDTH-1]),
        .dout_o     (dout_o),
        .oe_o       (dout_oe_o)
    );
endmodule

// File: rtl/dmsr_checker.sv
module dmsr_checker
    import dmsr_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input logic             clk,
    input logic             rst,
    input logic             par_mode_i,
    input logic             sdi_i,
    input logic             load_stb_i,
    input logic [WIDTH-1:0] load_data_i,
    input sclk_evt_t        sclk_evt,
    input logic [WIDTH-1:0] stage_q,
    input logic             dout_o,
    input logic             dout_oe_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (stage_q == '0 && dout_o == 1'b0));

    // R2
    load_captures_chk: assert property (@(posedge clk) disable iff (rst)
        (par_mode_i && load_stb_i) |=> stage_q == $past(load_data_i));

    // R4
    rise_shifts_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_mode_i && sclk_evt.rise) |=>
            stage_q == {$past(stage_q[WIDTH-2:0]), $past(sdi_i)});

    // R4
    edges_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sclk_evt.rise, sclk_evt.fall}));

    // R5
    latch_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_mode_i && !sclk_evt.fall) |=> $stable(dout_o));

    // R6
    latch_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        par_mode_i |=> dout_o == $past(stage_q[WIDTH-1]));

    // R7
    read_ignores_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_mode_i && !sclk_evt.rise) |=> $stable(stage_q));

    // R8
    load_ignores_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (par_mode_i && !load_stb_i) |=> $stable(stage_q));

    // R3
    oe_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(par_mode_i) |-> dout_oe_o);
endmodule

bind dual_mode_shift_reg dmsr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .par_mode_i  (par_mode_i),
    .sdi_i       (sdi_i),
    .load_stb_i  (load_stb_i),
    .load_data_i (load_data_i),
    .sclk_evt    (sclk_evt),
    .stage_q     (stage_q),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o)
);

// File: tb/dual_mode_shift_reg_tb.sv
module dual_mode_shift_reg_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         par_mode = 1'b1;
    logic         sclk = 1'b0;
    logic         tb_sdi = 1'b0;
    logic         casc = 1'b0;
    logic         stb = 1'b0;
    logic         up_stb = 1'b0;
    logic [W-1:0] ld = '0;
    logic         dout, oe, up_dout, up_oe, dut_sdi;

    int           n_cmp = 0;
    int           n_bad = 0;
    logic [W-1:0] m_q = '0;
    logic         m_out = 1'b0;
    bit           done = 1'b0;

    assign dut_sdi = casc ? up_dout : tb_sdi;

    always #5 clk = ~clk;

    dual_mode_shift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .par_mode_i(par_mode), .sclk_i(sclk),
        .sdi_i(dut_sdi), .load_stb_i(stb), .load_data_i(ld),
        .dout_o(dout), .dout_oe_o(oe)
    );

    dual_mode_shift_reg #(.WIDTH(W)) u_up (
        .clk(clk), .rst(rst), .par_mode_i(par_mode), .sclk_i(sclk),
        .sdi_i(1'b0), .load_stb_i(up_stb), .load_data_i(ld),
        .dout_o(up_dout), .dout_oe_o(up_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] shift_model(input logic [W-1:0] q, input logic b);
        return {q[W-2:0], b};
    endfunction

    task automatic go_mode(input logic m);
        par_mode = m;
        if (m) m_out = m_q[W-1];
        wait_cy(3);
    endtask

    task automatic load_word(input logic [W-1:0] w);
        ld  = w;
        stb = 1'b1;
        wait_cy(1);
        stb = 1'b0;
        wait_cy(3);
        if (par_mode) begin
            m_q   = w;
            m_out = w[W-1];
        end
    endtask

    task automatic pulse(input logic b_in, input logic b_exp);
        tb_sdi = b_in;
        wait_cy(1);
        sclk = 1'b1;
        wait_cy(6);
        chk("R10 output held while clock high", dout, m_out);
        if (!par_mode) m_q = shift_model(m_q, b_exp);
        sclk = 1'b0;
        wait_cy(6);
        if (!par_mode) m_out = m_q[W-1];
        chk("R5 output after falling edge", dout, m_out);
        chk("R3 output enable", oe, !par_mode);
    endtask

    task automatic read_bits(input int n, input logic [15:0] sin,
                             input logic use_ext, input logic [15:0] ext,
                             output logic [15:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got = {got[14:0], dout};
            pulse(sin[n-1-i], use_ext ? ext[n-1-i] : sin[n-1-i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [W-1:0] w, s;
        void'($urandom(32'd2024));

        wait_cy(4);
        rst = 1'b0;
        wait_cy(2);
        // R1 reset state, load mode
        chk("R1 dout after reset", dout, 1'b0);
        chk("R3 oe low in load mode", oe, 1'b0);
        go_mode(1'b0);
        chk("R3 oe high in read mode", oe, 1'b1);
        read_bits(W, 16'h0000, 1'b0, 16'h0, got);
        chk("R1 register empty after reset", got, 32'h0);

        // R2 / R6 directed load and read, R4 shifted-in pattern
        go_mode(1'b1);
        load_word(8'hA5);
        go_mode(1'b0);
        chk("R6 first bit present before clock", dout, 1'b1);
        read_bits(W, 16'h003C, 1'b0, 16'h0, got);
        chk("R2 loaded word read back", got, 32'hA5);
        go_mode(1'b1);
        chk("R6 latch follows last stage in load mode", dout, 1'b0);
        go_mode(1'b0);
        read_bits(W, 16'h0000, 1'b0, 16'h0, got);
        chk("R4 serial input shifted through", got, 32'h3C);

        // R8 clock edges ignored in load mode
        go_mode(1'b1);
        load_word(8'hFF);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        chk("R8 output unchanged by clock in load mode", dout, 1'b1);
        go_mode(1'b0);
        read_bits(W, 16'h005A, 1'b0, 16'h0, got);
        chk("R8 word intact after load-mode clocks", got, 32'hFF);

        // R7 load strobe ignored in read mode
        load_word(8'h00);
        chk("R7 output unchanged by strobe in read mode", dout, 1'b0);
        read_bits(W, 16'h0000, 1'b0, 16'h0, got);
        chk("R7 word intact after read-mode strobe", got, 32'h5A);

        // R9 two-register chain
        go_mode(1'b1);
        load_word(8'hC3);
        ld = 8'h96;
        up_stb = 1'b1;
        wait_cy(1);
        up_stb = 1'b0;
        wait_cy(3);
        casc = 1'b1;
        go_mode(1'b0);
        read_bits(2*W, 16'h0000, 1'b1, 16'h9600, got);
        chk("R9 chained 16-bit read", got, 32'hC396);
        casc = 1'b0;

        // Random words with random ignored events
        for (int it = 0; it < 24; it++) begin
            w = W'($urandom);
            s = W'($urandom);
            go_mode(1'b1);
            load_word(w);
            for (int k = 0; k < int'($urandom % 3); k++) pulse(1'($urandom), 1'b0);
            go_mode(1'b0);
            if ($urandom % 2 == 0) load_word(~w);
            read_bits(W, {8'h00, s}, 1'b0, 16'h0, got);
            chk("R2 random word read back", got, {24'h0, w});
            read_bits(W, 16'h0000, 1'b0, 16'h0, got);
            chk("R4 random serial input shifted through", got, {24'h0, s});
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule